// File: doc/BRIEF.md
# Chained I/O Channel Sequencer

This block runs a list of byte-transfer commands that software leaves in memory, so that the host does not have to move the bytes itself. The host pulses a start strobe together with the byte address of the first command. The sequencer reads the 8-byte command from memory, with the most significant byte at the lowest address. It then moves the requested number of bytes between a byte-wide device stream and a memory buffer. A flag bit in the command says whether another command follows. Chained commands sit back to back, each 8 bytes after the one before. One start can therefore fill or drain several separate buffers.

Memory is reached through a single byte port. Read data returns one cycle after the request is sampled, as it would from a synchronous block RAM. The device side has two ready/valid byte streams: one carries bytes into memory and the other carries bytes out of it. Once the last command finishes, or a command turns out to be malformed, the sequencer drops busy and raises a completion level. This level carries an error flag and stays up until the next accepted start.

Top module: `iochan_seq`

## Requirements
- R1: After reset, busy_o, done_o, err_o, mem_req_o, dev_in_ready_o and dev_out_valid_o are all 0.
- R2: An accepted start reads 8 consecutive memory bytes in ascending order, from the supplied address to address+7. The first byte read is bit 63:56 of the command and the last byte is bits 7:0.
- R3: Command fields are: bits 63:56 operation, bits 55:32 buffer address, bits 31:24 flags and bits 15:0 byte count. Bits 23:16 have no effect.
- R4: Operation 0x02 stores exactly `count` device-stream bytes at ascending addresses, starting at the buffer address, in the order they arrive.
- R5: Operation 0x01 reads `count` bytes from ascending addresses, starting at the buffer address, and offers them in that order on the outgoing device stream.
- R6: When flag bit 6 (value 0x40) is set, the sequencer fetches the next command from the current command address plus 8, but only after the last byte of the current command has moved. When flag bit 6 is clear, the program ends, whatever the other flag bits hold.
- R7: At the end of a program with no error, done_o=1, err_o=0 and busy_o=0. These levels hold until a new start is accepted. An accepted start clears done_o and sets busy_o. The memory port is idle whenever busy_o is 0.
- R8: An operation code other than 0x01 or 0x02, or a count of 0, ends the program without moving any byte, with done_o=1 and err_o=1.
- R9: A start strobe is ignored while busy_o is 1. This includes the cycle in which the final command completes.
- R10: dev_in_ready_o is high only during an operation 0x02 transfer, and no more than `count` bytes are accepted. While dev_out_valid_o is high and not accepted, dev_out_data_o holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, taken only when idle |
| prog_addr_i | input | 24 | Address of the first command |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 24 | Memory byte address |
| mem_wdata_o | output | 8 | Write byte |
| mem_rdata_i | input | 8 | Read byte, valid the cycle after the request is sampled |
| dev_in_valid_i | input | 1 | Device offers a byte for memory |
| dev_in_data_i | input | 8 | Incoming device byte |
| dev_in_ready_o | output | 1 | Sequencer takes the incoming byte |
| dev_out_valid_o | output | 1 | Sequencer offers a byte to the device |
| dev_out_data_o | output | 8 | Outgoing byte |
| dev_out_ready_i | input | 1 | Device takes the outgoing byte |
| busy_o | output | 1 | Program in progress |
| done_o | output | 1 | Program finished (level) |
| err_o | output | 1 | Program stopped on a malformed command |

## Verification
Two things can land on the same clock edge: the completion of the final command and a new start request. The bench provokes this by holding start_i high for the whole of a program and releasing it only at the first falling edge where done_o is seen. Success means that done_o then stays high, busy_o stays low and no further device bytes are consumed. A second case pulses start mid-transfer with another program address. That start is judged ignored when only one command fetch appears in the memory read log and the original buffer is complete.

// File: rtl/iochan_pkg.sv
package iochan_pkg;
  localparam int ADDR_W     = 24;
  localparam int LEN_W      = 16;
  localparam int BYTE_W     = 8;
  localparam int CMD_BYTES  = 8;
  localparam int CMD_BITS   = CMD_BYTES * BYTE_W;
  // field positions inside the assembled command
  localparam int OP_LSB     = CMD_BITS - BYTE_W;
  localparam int ADDR_LSB   = OP_LSB - ADDR_W;
  localparam int FLAG_LSB   = ADDR_LSB - BYTE_W;
  localparam int CHAIN_BIT  = 6;
  localparam logic [BYTE_W-1:0] OP_TO_MEM = 8'h02;
  localparam logic [BYTE_W-1:0] OP_TO_DEV = 8'h01;

  typedef struct packed {
    logic [BYTE_W-1:0] op;
    logic [ADDR_W-1:0] buf_addr;
    logic              chain;
    logic [LEN_W-1:0]  len;
  } cmd_t;

  typedef enum logic [1:0] {SQ_IDLE, SQ_FETCH, SQ_DECODE, SQ_MOVE} seq_state_t;
  typedef enum logic [2:0] {MV_IDLE, MV_ACCEPT, MV_FETCHB, MV_GAP, MV_LATCH, MV_OFFER} move_state_t;
endpackage

// File: rtl/iochan_fetch.sv
module iochan_fetch
  import iochan_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              go_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic              done_o,
  output cmd_t              cmd_o
);
  localparam int IDX_W = $clog2(CMD_BYTES) + 1;

  logic [IDX_W-1:0]    issued_q, got_q;
  logic                req_q, pend_q, done_q;
  logic [ADDR_W-1:0]   base_q, addr_q;
  logic [CMD_BITS-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      issued_q <= IDX_W'(CMD_BYTES);
      got_q    <= '0;
      req_q    <= 1'b0;
      pend_q   <= 1'b0;
      done_q   <= 1'b0;
      base_q   <= '0;
      addr_q   <= '0;
      word_q   <= '0;
    end else begin
      done_q <= 1'b0;
      pend_q <= req_q;
      if (go_i) begin
        base_q   <= base_i;
        issued_q <= '0;
        got_q    <= '0;
        req_q    <= 1'b0;
      end else if (issued_q < IDX_W'(CMD_BYTES)) begin
        req_q    <= 1'b1;
        addr_q   <= base_q + ADDR_W'(issued_q);
        issued_q <= issued_q + 1'b1;
      end else begin
        req_q <= 1'b0;
      end
      // bytes arrive most significant first
      if (pend_q) begin
        word_q <= {word_q[CMD_BITS-BYTE_W-1:0], rdata_i};
        got_q  <= got_q + 1'b1;
        if (got_q == IDX_W'(CMD_BYTES - 1)) done_q <= 1'b1;
      end
    end
  end

  assign req_o  = req_q;
  assign addr_o = addr_q;
  assign done_o = done_q;
  assign cmd_o  = '{op:       word_q[OP_LSB +: BYTE_W],
                    buf_addr: word_q[ADDR_LSB +: ADDR_W],
                    chain:    word_q[FLAG_LSB + CHAIN_BIT],
                    len:      word_q[LEN_W-1:0]};

  // R2: command bytes requested at ascending addresses
  a_r2_fetch_ascending: assert property (@(posedge clk) disable iff (rst)
    (req_q && $past(req_q)) |-> (addr_q == $past(addr_q) + ADDR_W'(1)));
endmodule

// File: rtl/iochan_move.sv
module iochan_move
  import iochan_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              go_i,
  input  logic              to_mem_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  input  logic              in_valid_i,
  input  logic [BYTE_W-1:0] in_data_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [BYTE_W-1:0] out_data_o,
  input  logic              out_ready_i,
  output logic              done_o
);
  move_state_t       st_q;
  logic [LEN_W-1:0]  left_q;
  logic [ADDR_W-1:0] ptr_q, maddr_q;
  logic [BYTE_W-1:0] mwdata_q, odata_q;
  logic              mreq_q, mwe_q, rdy_q, ovalid_q, done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= MV_IDLE;
      left_q   <= '0;
      ptr_q    <= '0;
      maddr_q  <= '0;
      mwdata_q <= '0;
      odata_q  <= '0;
      mreq_q   <= 1'b0;
      mwe_q    <= 1'b0;
      rdy_q    <= 1'b0;
      ovalid_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      mreq_q <= 1'b0;
      mwe_q  <= 1'b0;
      case (st_q)
        MV_IDLE: begin
          if (go_i) begin
            ptr_q  <= addr_i;
            left_q <= len_i;
            if (to_mem_i) begin
              st_q  <= MV_ACCEPT;
              rdy_q <= 1'b1;
            end else begin
              st_q <= MV_FETCHB;
            end
          end
        end
        MV_ACCEPT: begin
          if (in_valid_i && rdy_q) begin
            mreq_q   <= 1'b1;
            mwe_q    <= 1'b1;
            maddr_q  <= ptr_q;
            mwdata_q <= in_data_i;
            ptr_q    <= ptr_q + ADDR_W'(1);
            left_q   <= left_q - LEN_W'(1);
            if (left_q == LEN_W'(1)) begin
              rdy_q  <= 1'b0;
              done_q <= 1'b1;
              st_q   <= MV_IDLE;
            end
          end
        end
        MV_FETCHB: begin
          mreq_q  <= 1'b1;
          maddr_q <= ptr_q;
          st_q    <= MV_GAP;
        end
        MV_GAP: st_q <= MV_LATCH;
        MV_LATCH: begin
          odata_q  <= mem_rdata_i;
          ovalid_q <= 1'b1;
          st_q     <= MV_OFFER;
        end
        MV_OFFER: begin
          if (out_ready_i) begin
            ovalid_q <= 1'b0;
            ptr_q    <= ptr_q + ADDR_W'(1);
            left_q   <= left_q - LEN_W'(1);
            if (left_q == LEN_W'(1)) begin
              done_q <= 1'b1;
              st_q   <= MV_IDLE;
            end else begin
              st_q <= MV_FETCHB;
            end
          end
        end
        default: st_q <= MV_IDLE;
      endcase
    end
  end

  assign mem_req_o   = mreq_q;
  assign mem_we_o    = mwe_q;
  assign mem_addr_o  = maddr_q;
  assign mem_wdata_o = mwdata_q;
  assign in_ready_o  = rdy_q;
  assign out_valid_o = ovalid_q;
  assign out_data_o  = odata_q;
  assign done_o      = done_q;

  // R4: every accepted device byte becomes a memory write on the next cycle
  a_r4_accept_writes: assert property (@(posedge clk) disable iff (rst)
    (in_valid_i && in_ready_o) |=> (mem_req_o && mem_we_o));
  // R10: ready only while collecting bytes for memory
  a_r10_ready_in_accept: assert property (@(posedge clk) disable iff (rst)
    in_ready_o |-> (st_q == MV_ACCEPT));
  // R10: an offered byte holds until taken
  a_r10_offer_holds: assert property (@(posedge clk) disable iff (rst)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));
  // R5: no new memory read while a byte is still offered
  a_r5_one_byte_in_flight: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_we_o) |-> !out_valid_o);
endmodule

// File: rtl/iochan_seq.sv
module iochan_seq
  import iochan_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] prog_addr_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  input  logic              dev_in_valid_i,
  input  logic [BYTE_W-1:0] dev_in_data_i,
  output logic              dev_in_ready_o,
  output logic              dev_out_valid_o,
  output logic [BYTE_W-1:0] dev_out_data_o,
  input  logic              dev_out_ready_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  seq_state_t        st_q;
  logic [ADDR_W-1:0] cmd_addr_q;
  logic              fgo_q, mgo_q, busy_q, done_q, err_q;

  logic              f_req, f_done;
  logic [ADDR_W-1:0] f_addr;
  cmd_t              cmd;

  logic              m_req, m_we, m_done;
  logic [ADDR_W-1:0] m_addr;
  logic [BYTE_W-1:0] m_wdata;

  logic cmd_bad, chain_step;
  assign cmd_bad    = ((cmd.op != OP_TO_MEM) && (cmd.op != OP_TO_DEV)) || (cmd.len == '0);
  assign chain_step = (st_q == SQ_MOVE) && m_done && cmd.chain;

  iochan_fetch u_fetch (
    .clk     (clk),
    .rst     (rst),
    .go_i    (fgo_q),
    .base_i  (cmd_addr_q),
    .req_o   (f_req),
    .addr_o  (f_addr),
    .rdata_i (mem_rdata_i),
    .done_o  (f_done),
    .cmd_o   (cmd)
  );

  iochan_move u_move (
    .clk         (clk),
    .rst         (rst),
    .go_i        (mgo_q),
    .to_mem_i    (cmd.op == OP_TO_MEM),
    .addr_i      (cmd.buf_addr),
    .len_i       (cmd.len),
    .mem_req_o   (m_req),
    .mem_we_o    (m_we),
    .mem_addr_o  (m_addr),
    .mem_wdata_o (m_wdata),
    .mem_rdata_i (mem_rdata_i),
    .in_valid_i  (dev_in_valid_i),
    .in_data_i   (dev_in_data_i),
    .in_ready_o  (dev_in_ready_o),
    .out_valid_o (dev_out_valid_o),
    .out_data_o  (dev_out_data_o),
    .out_ready_i (dev_out_ready_i),
    .done_o      (m_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= SQ_IDLE;
      cmd_addr_q <= '0;
      fgo_q      <= 1'b0;
      mgo_q      <= 1'b0;
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      fgo_q <= 1'b0;
      mgo_q <= 1'b0;
      case (st_q)
        SQ_IDLE: begin
          if (start_i) begin
            cmd_addr_q <= prog_addr_i;
            fgo_q      <= 1'b1;
            busy_q     <= 1'b1;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
            st_q       <= SQ_FETCH;
          end
        end
        SQ_FETCH: if (f_done) st_q <= SQ_DECODE;
        SQ_DECODE: begin
          if (cmd_bad) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            err_q  <= 1'b1;
            st_q   <= SQ_IDLE;
          end else begin
            mgo_q <= 1'b1;
            st_q  <= SQ_MOVE;
          end
        end
        SQ_MOVE: begin
          if (m_done) begin
            if (cmd.chain) begin
              cmd_addr_q <= cmd_addr_q + ADDR_W'(CMD_BYTES);
              fgo_q      <= 1'b1;
              st_q       <= SQ_FETCH;
            end else begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
              st_q   <= SQ_IDLE;
            end
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  // the fetch and move units never request in the same cycle
  assign mem_req_o   = f_req | m_req;
  assign mem_we_o    = m_we;
  assign mem_addr_o  = f_req ? f_addr : m_addr;
  assign mem_wdata_o = m_wdata;
  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign err_o       = err_q;

  // R7: memory port idle outside a program
  a_r7_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !mem_req_o);
  // R7: completion and busy are exclusive
  a_r7_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);
  // R8: error only reported together with completion
  a_r8_err_with_done: assert property (@(posedge clk) disable iff (rst)
    err_o |-> done_o);
  // R9: start while busy leaves the command pointer alone
  a_r9_busy_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i && !chain_step) |=> $stable(cmd_addr_q));
  // R6: fetch and move units never share the memory port
  a_r6_port_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(f_req && m_req));
endmodule

// File: tb/iochan_seq_tb_top.sv
`timescale 1ns/100ps
module iochan_seq_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        start_i = 1'b0;
  logic [23:0] prog_addr = '0;
  logic        mem_req, mem_we;
  logic [23:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        dev_in_valid, dev_in_ready;
  logic [7:0]  dev_in_data;
  logic        dev_out_valid, dev_out_ready;
  logic [7:0]  dev_out_data;
  logic        busy, done, err;

  iochan_seq dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .prog_addr_i(prog_addr),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .dev_in_valid_i(dev_in_valid), .dev_in_data_i(dev_in_data), .dev_in_ready_o(dev_in_ready),
    .dev_out_valid_o(dev_out_valid), .dev_out_data_o(dev_out_data), .dev_out_ready_i(dev_out_ready),
    .busy_o(busy), .done_o(done), .err_o(err)
  );

  // memory model with a host preload port
  logic [7:0]  mem [0:4095];
  logic        hp_we = 1'b0;
  logic [11:0] hp_addr = '0;
  logic [7:0]  hp_data = '0;
  always @(posedge clk) begin
    if (hp_we) mem[hp_addr] <= hp_data;
    else if (mem_req && mem_we) mem[mem_addr[11:0]] <= mem_wdata;
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[11:0]];
  end

  // device stream models and read-address log
  logic [7:0]  src [0:511];
  logic [7:0]  sink [0:511];
  logic [23:0] rd_log [0:31];
  int src_idx = 0, sink_n = 0, rd_n = 0, src_len = 512, cyc = 0;
  logic stream_clr = 1'b0;
  assign dev_in_valid  = (src_idx < src_len) && (cyc % 5 != 3);
  assign dev_in_data   = src[src_idx[8:0]];
  assign dev_out_ready = (cyc % 3 != 1);
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (stream_clr) begin
      src_idx <= 0; sink_n <= 0; rd_n <= 0;
    end else begin
      if (dev_in_valid && dev_in_ready) src_idx <= src_idx + 1;
      if (dev_out_valid && dev_out_ready) begin
        sink[sink_n[8:0]] <= dev_out_data;
        sink_n <= sink_n + 1;
      end
      if (mem_req && !mem_we && rd_n < 32) begin
        rd_log[rd_n[4:0]] <= mem_addr;
        rd_n <= rd_n + 1;
      end
    end
  end

  int n_checks = 0, n_fail = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic hw(input int a, input int d);
    hp_addr = a[11:0]; hp_data = d[7:0]; hp_we = 1'b1;
    @(negedge clk);
    hp_we = 1'b0;
  endtask

  task automatic put_cmd(input int at, input int op, input int baddr, input int flags,
                         input int spare, input int len);
    logic [63:0] w;
    w = {op[7:0], baddr[23:0], flags[7:0], spare[7:0], len[15:0]};
    for (int i = 0; i < 8; i++) hw(at + i, int'(w[63 - 8*i -: 8]));
  endtask

  task automatic clr_streams();
    @(negedge clk); stream_clr = 1'b1;
    @(negedge clk); stream_clr = 1'b0;
  endtask

  task automatic go(input int a);
    @(negedge clk); start_i = 1'b1; prog_addr = a[23:0];
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic wait_done(input int max);
    int k;
    k = 0;
    while (!done && k < max) begin @(negedge clk); k++; end
    chk(done, "R7 completion watchdog", int'(done), 1);
  endtask

  function automatic int wpat(input int i);
    return (i * 13 + 1) & 255;
  endfunction

  // vector: op, flags, spare, len, expected error
  localparam logic [47:0] VEC [6] = '{
    {8'h02, 8'h00, 8'h00, 16'd5, 8'd0},
    {8'h01, 8'h00, 8'h00, 16'd7, 8'd0},
    {8'h02, 8'h80, 8'hFF, 16'd1, 8'd0},
    {8'h03, 8'h00, 8'h00, 16'd4, 8'd1},
    {8'h02, 8'h00, 8'h00, 16'd0, 8'd1},
    {8'h01, 8'hBF, 8'h00, 16'd3, 8'd0}
  };

  initial begin
    int wd;
    wd = 0;
    while (wd < 150000) begin @(posedge clk); wd++; end
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", wd);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) src[i] = 8'((i * 7 + 3) & 255);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !err, "R1 status after reset", int'({busy, done, err}), 0);
    chk(!mem_req && !dev_in_ready && !dev_out_valid, "R1 ports quiet after reset",
        int'({mem_req, dev_in_ready, dev_out_valid}), 0);

    // table of single-command programs
    for (int v = 0; v < 6; v++) begin
      int op, fl, sp, ln, xe;
      bit ok;
      op = int'(VEC[v][47:40]); fl = int'(VEC[v][39:32]); sp = int'(VEC[v][31:24]);
      ln = int'(VEC[v][23:8]);  xe = int'(VEC[v][7:0]);
      put_cmd(12'h100, op, 12'h400, fl, sp, ln);
      put_cmd(12'h108, 2, 12'h500, 0, 0, 2);   // trap reached only by a wrong chain
      hw(12'h500, 8'hEE); hw(12'h501, 8'hEE);
      for (int i = 0; i < 8; i++) hw(12'h400 + i, wpat(i + v));
      clr_streams();
      go(12'h100);
      wait_done(5000);
      chk(int'(err) == xe, "R8 error flag per vector", int'(err), xe);
      chk(mem[12'h500] == 8'hEE && mem[12'h501] == 8'hEE, "R6 no chain without bit 6",
          int'(mem[12'h500]), 8'hEE);
      if (xe != 0) begin
        chk(src_idx == 0 && sink_n == 0, "R8 nothing moved on bad command",
            src_idx + sink_n, 0);
      end else if (op == 2) begin
        ok = (src_idx == ln);
        for (int i = 0; i < ln; i++) if (mem[12'h400 + i] != src[i]) ok = 1'b0;
        chk(ok, "R4 R3 device bytes stored", src_idx, ln);
      end else begin
        ok = (sink_n == ln);
        for (int i = 0; i < ln; i++) if (int'(sink[i]) != wpat(i + v)) ok = 1'b0;
        chk(ok, "R5 memory bytes sent", sink_n, ln);
      end
    end

    // R2 R4 R6: three chained reads of 100 bytes to three buffers
    put_cmd(0,  2, 12'h200, 8'h40, 0, 100);
    put_cmd(8,  2, 12'h300, 8'h40, 0, 100);
    put_cmd(16, 2, 12'h600, 8'h00, 0, 100);
    clr_streams();
    go(0);
    wait_done(20000);
    chk(!err && !busy, "R7 clean end after chain", int'({err, busy}), 0);
    begin
      bit ok;
      ok = (src_idx == 300);
      for (int i = 0; i < 100; i++) begin
        if (mem[12'h200 + i] != src[i])       ok = 1'b0;
        if (mem[12'h300 + i] != src[100 + i]) ok = 1'b0;
        if (mem[12'h600 + i] != src[200 + i]) ok = 1'b0;
      end
      chk(ok, "R6 R4 three buffers filled in order", src_idx, 300);
      ok = (rd_n == 24);
      for (int i = 0; i < 24; i++) if (rd_log[i] != 24'(i)) ok = 1'b0;
      chk(ok, "R2 fetch addresses ascend by command", rd_n, 24);
    end

    // R5 R6: chained write then read
    for (int i = 0; i < 4; i++) hw(12'h700 + i, 8'hA0 + i);
    put_cmd(12'h0C0, 1, 12'h700, 8'h40, 0, 4);
    put_cmd(12'h0C8, 2, 12'h780, 8'h00, 0, 3);
    clr_streams();
    go(12'h0C0);
    wait_done(5000);
    begin
      bit ok;
      ok = (sink_n == 4) && (src_idx == 3);
      for (int i = 0; i < 4; i++) if (sink[i] != 8'(8'hA0 + i)) ok = 1'b0;
      for (int i = 0; i < 3; i++) if (mem[12'h780 + i] != src[i]) ok = 1'b0;
      chk(ok, "R5 R6 mixed chain", sink_n * 10 + src_idx, 43);
    end

    // R9: start pulse in the middle of a run is ignored
    put_cmd(12'h140, 2, 12'h800, 8'h00, 0, 50);
    clr_streams();
    go(12'h140);
    repeat (30) @(negedge clk);
    go(12'h100);
    wait_done(5000);
    chk(rd_n == 8 && src_idx == 50, "R9 mid-run start ignored", rd_n * 100 + src_idx, 850);

    // R9 R7: start held through the completion edge
    put_cmd(12'h180, 2, 12'h880, 8'h00, 0, 2);
    clr_streams();
    @(negedge clk); start_i = 1'b1; prog_addr = 24'h180;
    begin
      int k;
      k = 0;
      @(negedge clk);
      while (!done && k < 2000) begin @(negedge clk); k++; end
    end
    start_i = 1'b0;
    repeat (5) @(negedge clk);
    chk(done && !busy && src_idx == 2, "R9 start at completion edge ignored",
        int'({done, busy}) * 100 + src_idx, 202);

    // R7: accepted start clears done and raises busy
    clr_streams();
    @(negedge clk); start_i = 1'b1; prog_addr = 24'h180;
    @(negedge clk); start_i = 1'b0;
    chk(!done && busy, "R7 done cleared by new start", int'({done, busy}), 1);
    wait_done(2000);
    chk(!err, "R7 second run clean", int'(err), 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule